// File: doc/BRIEF.md
# Quantized coefficient scaler

This block turns one entropy-decoded transform coefficient into the signed 16-bit value that an inverse DCT stage consumes. Each incoming 16-bit word carries a signed 10-bit coefficient in its low bits. The block multiplies that coefficient by an unsigned quantizer step, scales the product, and applies a small rounding bias toward zero. It then limits the result to a symmetric signed range and registers it.

A one-bit mode select picks the scaling rule. The direct rule scales the product by 16. The AC rule first divides the product by 8 with an arithmetic (floor) shift, then scales by 16. A quantizer step of zero bypasses both rules and uses a fixed doubling path with no bias.

Words are accepted on a valid strobe. Each accepted word yields one result with its own valid strobe exactly one cycle later. Words may arrive on every cycle.

Top module: `qcoef_scaler`

## Requirements
- R1: The coefficient is bits [9:0] of `coef_word`, read as a two's-complement 10-bit value; bits [15:10] have no effect on the result.
- R2: With `scale_mode` = 0 (direct) and a nonzero `q_step`, the unbiased result is coefficient × q_step × 16.
- R3: With `scale_mode` = 1 (AC) and a nonzero `q_step`, the unbiased result is floor(coefficient × q_step / 8) × 16.
- R4: With a nonzero `q_step`, the bias added to the unbiased result is +8 for a negative coefficient, −8 for a positive coefficient, and 0 for a zero coefficient.
- R5: With `q_step` = 0, the result is coefficient × 32 with no bias, in either mode.
- R6: The result is saturated to the range −16383 to +16383 before it is output.
- R7: `res_valid` is high in exactly the cycles that follow a cycle with `coef_valid` high, and `res_data` carries that word's result in that cycle; words may arrive back to back.
- R8: In a cycle that follows one with `coef_valid` low, `res_data` keeps its previous value.
- R9: While `rst_n` is low at a clock edge, `res_valid` and `res_data` clear to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| coef_valid | input | 1 | Input word is present this cycle |
| coef_word | input | 16 | Coefficient word, signed coefficient in bits [9:0] |
| q_step | input | 6 | Unsigned quantizer step |
| scale_mode | input | 1 | 0 = direct scaling, 1 = AC scaling |
| res_valid | output | 1 | Result is present this cycle |
| res_data | output | 16 | Signed dequantized result |

## Verification
The assertions assume `coef_valid`, `coef_word`, `q_step` and `scale_mode` are stable and known around each rising edge once reset is released, and that the coefficient value −512 is the only one whose doubled path reaches the saturation limit. The stimulus drives every input on the falling edge, holds it until the next falling edge, and mixes hand-picked corners (zero, ±1, extreme coefficients, zero and maximum steps, garbage in the upper word bits) with random words, random gaps and runs of back-to-back words. A behavioural integer model predicts each cycle's outputs and the bench compares them on every clock.

// File: rtl/qscale_pkg.sv
// Shared types and constants for the quantized coefficient scaler.
package qscale_pkg;

    // Scaling rule selected per input word.
    typedef enum logic {
        SCALE_DIRECT = 1'b0,
        SCALE_AC     = 1'b1
    } scale_mode_e;

    // Right shift applied to the product in AC mode (divide by 8).
    localparam int AC_DIV_SHIFT  = 3;
    // Left shift applied after scaling in both nonzero-step modes.
    localparam int POST_SHIFT    = 4;
    // Left shift of the doubling path used when the step is zero (x2 then x16).
    localparam int ZERO_Q_SHIFT  = 5;
    // Magnitude of the rounding bias applied toward zero.
    localparam int BIAS_MAG      = 8;

    // Unpacked coefficient and its sign flags.
    typedef struct packed {
        logic neg;
        logic zero;
    } coef_flags_t;

endpackage

// File: rtl/qs_coef_unpack.sv
// Extracts the signed coefficient field from an input word.
// Assumes the coefficient sits in the COEF_W least significant bits and is
// two's complement; all higher word bits are discarded.
module qs_coef_unpack
    import qscale_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int COEF_W = 10
) (
    input  logic [WORD_W-1:0]        word_in,
    output logic signed [COEF_W-1:0] coef,
    output coef_flags_t              flags
);

    // Slice the field and derive its sign and zero flags.
    always_comb begin
        coef       = $signed(word_in[COEF_W-1:0]);
        flags.neg  = word_in[COEF_W-1];
        flags.zero = (word_in[COEF_W-1:0] == '0);
    end

endmodule

// File: rtl/qs_scale_core.sv
// Multiplies the coefficient by the quantizer step and applies the scaling
// rule chosen by the mode, or the doubling path when the step is zero.
// Assumes the step is unsigned; the output is unbiased and unclamped and is
// wide enough that no intermediate value wraps.
module qs_scale_core
    import qscale_pkg::*;
#(
    parameter int COEF_W = 10,
    parameter int Q_W    = 6,
    parameter int WIDE_W = COEF_W + Q_W + 6
) (
    input  logic signed [COEF_W-1:0] coef,
    input  logic [Q_W-1:0]           q_step,
    input  scale_mode_e              mode,
    output logic                     q_is_zero,
    output logic signed [WIDE_W-1:0] scaled
);

    localparam int PROD_W = COEF_W + Q_W + 1;

    logic signed [PROD_W-1:0] coef_ext;
    logic signed [PROD_W-1:0] step_ext;
    logic signed [PROD_W-1:0] product;
    logic signed [PROD_W-1:0] product_div;
    logic signed [WIDE_W-1:0] nonzero_path;
    logic signed [WIDE_W-1:0] zero_path;

    // Form the signed product of coefficient and zero-extended step.
    always_comb begin
        coef_ext = PROD_W'(coef);
        step_ext = $signed({{(PROD_W-Q_W){1'b0}}, q_step});
        product  = coef_ext * step_ext;
    end

    // Optionally floor-divide the product by 8 for AC mode.
    always_comb begin
        if (mode == SCALE_AC) begin
            product_div = product >>> AC_DIV_SHIFT;
        end else begin
            product_div = product;
        end
    end

    // Scale both candidate paths and pick one on the step value.
    always_comb begin
        nonzero_path = WIDE_W'(product_div) <<< POST_SHIFT;
        zero_path    = WIDE_W'(coef) <<< ZERO_Q_SHIFT;
        q_is_zero    = (q_step == '0);
        scaled       = q_is_zero ? zero_path : nonzero_path;
    end

endmodule

// File: rtl/qs_bias_clamp.sv
// Adds the toward-zero rounding bias and saturates to a symmetric range.
// Assumes the bias only applies when the step is nonzero, and that the wide
// input never reaches the ends of its own range.
module qs_bias_clamp
    import qscale_pkg::*;
#(
    parameter int WIDE_W  = 22,
    parameter int OUT_W   = 16,
    parameter int SAT_MAG = 16383
) (
    input  logic signed [WIDE_W-1:0] scaled,
    input  logic                     q_is_zero,
    input  coef_flags_t              flags,
    output logic signed [OUT_W-1:0]  result
);

    localparam logic signed [WIDE_W-1:0] POS_LIM  = WIDE_W'(SAT_MAG);
    localparam logic signed [WIDE_W-1:0] NEG_LIM  = -WIDE_W'(SAT_MAG);
    localparam logic signed [WIDE_W-1:0] BIAS_POS = WIDE_W'(BIAS_MAG);
    localparam logic signed [WIDE_W-1:0] BIAS_NEG = -WIDE_W'(BIAS_MAG);

    logic signed [WIDE_W-1:0] bias;
    logic signed [WIDE_W-1:0] biased;
    logic signed [WIDE_W-1:0] limited;

    // Choose the bias from the coefficient sign; none on the zero-step path.
    always_comb begin
        if (q_is_zero || flags.zero) begin
            bias = '0;
        end else if (flags.neg) begin
            bias = BIAS_POS;
        end else begin
            bias = BIAS_NEG;
        end
        biased = scaled + bias;
    end

    // Saturate to the symmetric output range and narrow.
    always_comb begin
        if (biased > POS_LIM) begin
            limited = POS_LIM;
        end else if (biased < NEG_LIM) begin
            limited = NEG_LIM;
        end else begin
            limited = biased;
        end
        result = OUT_W'(limited);
    end

endmodule

// File: rtl/qcoef_scaler.sv
// Quantized coefficient scaler: extracts a signed coefficient from each
// valid input word, dequantizes it by the step and mode, biases it toward
// zero, saturates it, and registers the result with a one-cycle latency.
// Assumes inputs are stable around the rising edge; accepts a word every cycle.
module qcoef_scaler
    import qscale_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int COEF_W  = 10,
    parameter int Q_W     = 6,
    parameter int OUT_W   = 16,
    parameter int SAT_MAG = 16383
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_valid,
    input  logic [WORD_W-1:0] coef_word,
    input  logic [Q_W-1:0]    q_step,
    input  logic              scale_mode,
    output logic              res_valid,
    output logic [OUT_W-1:0]  res_data
);

    localparam int WIDE_W = COEF_W + Q_W + 6;

    logic signed [COEF_W-1:0] coef;
    coef_flags_t              flags;
    logic                     q_is_zero;
    logic signed [WIDE_W-1:0] scaled;
    logic signed [OUT_W-1:0]  result;
    scale_mode_e              mode;

    // Map the raw mode pin onto the shared enum.
    always_comb begin
        mode = scale_mode_e'(scale_mode);
    end

    qs_coef_unpack #(
        .WORD_W (WORD_W),
        .COEF_W (COEF_W)
    ) u_unpack (
        .word_in (coef_word),
        .coef    (coef),
        .flags   (flags)
    );

    qs_scale_core #(
        .COEF_W (COEF_W),
        .Q_W    (Q_W),
        .WIDE_W (WIDE_W)
    ) u_scale (
        .coef      (coef),
        .q_step    (q_step),
        .mode      (mode),
        .q_is_zero (q_is_zero),
        .scaled    (scaled)
    );

    qs_bias_clamp #(
        .WIDE_W  (WIDE_W),
        .OUT_W   (OUT_W),
        .SAT_MAG (SAT_MAG)
    ) u_clamp (
        .scaled    (scaled),
        .q_is_zero (q_is_zero),
        .flags     (flags),
        .result    (result)
    );

    // Output register: capture a result for each accepted word, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= coef_valid;
            if (coef_valid) begin
                res_data <= result;
            end
        end
    end

    // R7: a result follows every accepted word after one cycle.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid |=> res_valid);

    // R7: no result appears without a word one cycle earlier.
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_valid |=> !res_valid);

    // R8: the result register holds while no word is accepted.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_valid |=> $stable(res_data));

    // R6: every presented result lies inside the symmetric range.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($signed(res_data) <= $signed(OUT_W'(SAT_MAG)) &&
                       $signed(res_data) >= -$signed(OUT_W'(SAT_MAG))));

    // R4: a zero coefficient produces exactly zero.
    a_r4_zero_coef: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid && coef_word[COEF_W-1:0] == '0) |=> (res_data == '0));

    // R5: the zero-step path yields a multiple of 32 below the clamp limit.
    a_r5_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid && q_step == '0 && !(coef_word[COEF_W-1] && coef_word[COEF_W-2:0] == '0))
        |=> (res_data[4:0] == 5'd0));

    // R2: in direct mode a negative coefficient with nonzero step stays negative.
    a_r2_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid && !scale_mode && q_step != '0 && coef_word[COEF_W-1])
        |=> res_data[OUT_W-1]);

endmodule

// File: tb/qcoef_scaler_tb.sv
module qcoef_scaler_tb;

    localparam int WORD_W = 16;
    localparam int Q_W    = 6;
    localparam int OUT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              coef_valid = 1'b0;
    logic [WORD_W-1:0] coef_word = '0;
    logic [Q_W-1:0]    q_step = '0;
    logic              scale_mode = 1'b0;
    logic              res_valid;
    logic [OUT_W-1:0]  res_data;

    int    n_checks = 0;
    int    n_fail   = 0;
    logic  exp_valid = 1'b0;
    logic [OUT_W-1:0] exp_data = '0;
    string cur_tag = "R9";
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    qcoef_scaler u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .coef_valid (coef_valid),
        .coef_word  (coef_word),
        .q_step     (q_step),
        .scale_mode (scale_mode),
        .res_valid  (res_valid),
        .res_data   (res_data)
    );

    // Behavioural model of the dequantization rule (R1..R6).
    function automatic int model(input logic [15:0] w, input int q, input bit ac);
        int ci;
        int v;
        ci = int'(w & 16'h03FF);
        if (ci >= 512) ci = ci - 1024;
        if (q == 0) begin
            v = ci * 32;
        end else begin
            v = ci * q;
            if (ac) v = v >>> 3;
            v = v * 16;
            if (ci < 0) v = v + 8;
            else if (ci > 0) v = v - 8;
        end
        if (v > 16383) v = 16383;
        if (v < -16383) v = -16383;
        return v;
    endfunction

    // Compare outputs against the model, then drive the next cycle's inputs.
    task automatic step(input bit rst_b, input bit v, input logic [15:0] w,
                        input int q, input bit ac, input string tag);
        @(negedge clk);
        n_checks++;
        if (res_valid !== exp_valid || res_data !== exp_data) begin
            n_fail++;
            $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                     cur_tag, res_valid, $signed(res_data), exp_valid, $signed(exp_data));
        end
        rst_n      = rst_b;
        coef_valid = v;
        coef_word  = w;
        q_step     = Q_W'(q);
        scale_mode = ac;
        if (!rst_b) begin
            exp_valid = 1'b0;
            exp_data  = '0;
        end else begin
            exp_valid = v;
            if (v) exp_data = OUT_W'(model(w, q, ac));
        end
        cur_tag = tag;
    endtask

    initial begin
        // R9: reset clears outputs, even with a word presented.
        step(0, 1, 16'h0123, 5, 0, "R9");
        step(0, 1, 16'h0123, 5, 0, "R9");
        step(1, 0, 16'h0000, 0, 0, "R9");
        // R2: direct mode basics.
        step(1, 1, 16'h0001, 1, 0, "R2");
        step(1, 1, 16'h03FF, 1, 0, "R2");
        step(1, 1, 16'h0007, 3, 0, "R2");
        // R3: AC mode floors before scaling; +1 with step 1 biases to -8.
        step(1, 1, 16'h0001, 1, 1, "R3");
        step(1, 1, 16'h03FF, 1, 1, "R3");
        step(1, 1, 16'h0019, 7, 1, "R3");
        step(1, 1, 16'h03F0, 9, 1, "R3");
        // R4: zero coefficient gets no bias in either mode.
        step(1, 1, 16'h0000, 17, 0, "R4");
        step(1, 1, 16'h0000, 17, 1, "R4");
        // R5: zero step doubles, no bias, mode ignored.
        step(1, 1, 16'h0005, 0, 0, "R5");
        step(1, 1, 16'h03FB, 0, 1, "R5");
        step(1, 1, 16'h01FF, 0, 0, "R5");
        // R6: saturation at both ends, including the -512 zero-step case.
        step(1, 1, 16'h01FF, 63, 0, "R6");
        step(1, 1, 16'h0200, 63, 0, "R6");
        step(1, 1, 16'h0200, 0, 1, "R6");
        step(1, 1, 16'h01FF, 63, 1, "R6");
        // R1: upper word bits must not matter.
        step(1, 1, 16'hFC05, 4, 0, "R1");
        step(1, 1, 16'hA9FB, 4, 1, "R1");
        step(1, 1, 16'h5400, 9, 0, "R1");
        // R8: gaps hold the last value even with changing idle inputs.
        step(1, 0, 16'h0155, 33, 0, "R8");
        step(1, 0, 16'h02AA, 12, 1, "R8");
        step(1, 0, 16'h0000, 0, 0, "R8");
        // R7: back-to-back words then random traffic with gaps.
        for (int i = 0; i < 4000; i++) begin
            step(1, ($urandom % 4) != 0, 16'($urandom), int'($urandom % 64),
                 bit'($urandom % 2), "R7");
        end
        // R9: reset in mid-stream.
        step(0, 1, 16'h0011, 2, 0, "R9");
        step(1, 1, 16'h0011, 2, 0, "R9");
        step(1, 0, 16'h0000, 0, 0, "R8");
        step(1, 0, 16'h0000, 0, 0, "R8");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule